// File: doc/BRIEF.md
# Hardware Thread Fetch Selector

This block decides, every clock cycle, which hardware thread context of a multithreaded pipeline supplies the next instruction fetch. It holds one program counter per thread and drives the chosen thread's number and counter toward fetch. Each cycle the pipeline returns the selected thread's next address on `next_pc_i`. Each thread also has a ready flag, so a stalled context can be passed over.

A 2-bit policy input picks one of three scheduling schemes. In the interleaved scheme the thread changes every cycle in rotating order, skipping stalled threads. In the switch-on-event scheme one thread runs until a long-latency miss is reported. The selector then raises a flush for the old thread's work and moves to another ready thread. A refill window follows, and its output marks fetches as not yet committing. In the favoured-thread scheme one nominated thread always wins while it is ready, and the others share the slots it leaves.

The miss input is a single event strobe. A configuration without caches drives it from the data-access strobe, so that every memory reference causes a switch. Updates to the program counters come only through `next_pc_i`. Branch handling, caches and register state sit outside this block.

Top module: `thread_select`

## Requirements
- R1: `pc_o` is the stored program counter of thread `tid_o`; on a cycle with `valid_o` high and `flush_o` low, that thread's counter takes `next_pc_i` at the clock edge, and no other thread's counter changes.
- R2: Reset loads thread i's counter from bits [i*PC_W +: PC_W] of `rst_vec_i`, points the rotation at thread 0, clears the refill window and keeps `flush_o` low; with all threads ready and policy 0, the first four grants after reset are threads 0, 1, 2, 3 with their reset vectors.
- R3: Policy 0 (interleaved) grants the first ready thread found by scanning upward, with wrap-around, from the rotation pointer; after a grant the pointer becomes the granted thread plus one, modulo N_THREADS, so with two or more threads ready the grant changes every cycle.
- R4: When no thread is ready under policy 0, 2 or 3, `valid_o` is low and the rotation pointer keeps its value.
- R5: Policy 1 (switch-on-event) keeps `tid_o` on the current thread while no switch happens; `valid_o` then follows that thread's ready flag, giving a bubble when it is stalled.
- R6: Under policy 1, `long_miss_i` high while some other thread is ready raises `flush_o` in the same cycle, leaves the missing thread's counter unchanged, and from the next cycle makes the current thread the first ready thread found scanning upward from the old current thread plus one; if no other thread is ready there is no flush and no switch.
- R7: After a switch, `refill_busy_o` is high for exactly REFILL_CYCLES cycles, unless another switch restarts the window.
- R8: Policy 2 (favoured) grants `pref_tid_i` whenever that thread is ready; otherwise it grants as in R3.
- R9: Policy code 3 behaves exactly like policy 0.
- R10: `long_miss_i` has no effect under policies 0, 2 and 3: `flush_o` stays low and the grants are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Policy: 0 interleaved, 1 switch-on-event, 2 favoured, 3 as 0 |
| pref_tid_i | input | TID_W | Favoured thread under policy 2 |
| ready_i | input | N_THREADS | Per-thread ready flag (low means stalled) |
| long_miss_i | input | 1 | Costly stall of the current thread (policy 1 only) |
| next_pc_i | input | PC_W | Next counter value for the thread granted this cycle |
| rst_vec_i | input | N_THREADS*PC_W | Per-thread reset vectors |
| valid_o | output | 1 | A thread is granted this cycle |
| tid_o | output | TID_W | Granted thread |
| pc_o | output | PC_W | Counter of the granted thread |
| flush_o | output | 1 | Discard the old thread's work in the pipeline |
| refill_busy_o | output | 1 | Refill window after a switch; fetch is not committing |

## Verification
A wrong rotation pointer shows up within one cycle as an unexpected `tid_o`, because the next grant is the first ready thread after the last one. A corrupted per-thread counter appears on `pc_o` as soon as that thread is next granted, which is within N_THREADS cycles while it is ready. A wrong current thread or refill count under policy 1 shows immediately on `tid_o` or `refill_busy_o`. A flush on the wrong cycle shows on `flush_o` and, in later grants, as a counter that advanced when it should have been held.

// File: rtl/thread_select_pkg.sv
package thread_select_pkg;

    typedef enum logic [1:0] {
        SEL_FINE   = 2'd0,
        SEL_COARSE = 2'd1,
        SEL_PREF   = 2'd2,
        SEL_ALT    = 2'd3
    } sel_mode_e;

endpackage

// File: rtl/thread_rr_pick.sv
module thread_rr_pick #(
    parameter int N_THREADS = 4,
    parameter int TID_W     = 2
) (
    input  logic [N_THREADS-1:0] req_i,
    input  logic [TID_W-1:0]     start_i,
    output logic                 found_o,
    output logic [TID_W-1:0]     idx_o
);

    // scan upward from start_i with wrap-around, first hit wins
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N_THREADS; k++) begin
            if (!found_o && req_i[(int'(start_i) + k) % N_THREADS]) begin
                found_o = 1'b1;
                idx_o   = TID_W'((int'(start_i) + k) % N_THREADS);
            end
        end
    end

endmodule

// File: rtl/thread_pc_bank.sv
module thread_pc_bank #(
    parameter int N_THREADS = 4,
    parameter int PC_W      = 32,
    parameter int TID_W     = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_THREADS*PC_W-1:0]     rst_vec_i,
    input  logic                          wr_en_i,
    input  logic [TID_W-1:0]              wr_tid_i,
    input  logic [PC_W-1:0]               wr_pc_i,
    output logic [N_THREADS-1:0][PC_W-1:0] pcs_o
);

    logic [N_THREADS-1:0][PC_W-1:0] pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (wr_en_i) begin
            pc_d[wr_tid_i] = wr_pc_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_THREADS; i++) begin
                pc_q[i] <= rst_vec_i[i*PC_W +: PC_W];
            end
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pcs_o = pc_q;

endmodule

// File: rtl/thread_select.sv
module thread_select
    import thread_select_pkg::*;
#(
    parameter int N_THREADS     = 4,
    parameter int PC_W          = 32,
    parameter int REFILL_CYCLES = 5,
    localparam int TID_W        = (N_THREADS > 1) ? $clog2(N_THREADS) : 1,
    localparam int CNT_W        = (REFILL_CYCLES > 0) ? $clog2(REFILL_CYCLES + 1) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_i,
    input  logic [TID_W-1:0]          pref_tid_i,
    input  logic [N_THREADS-1:0]      ready_i,
    input  logic                      long_miss_i,
    input  logic [PC_W-1:0]           next_pc_i,
    input  logic [N_THREADS*PC_W-1:0] rst_vec_i,
    output logic                      valid_o,
    output logic [TID_W-1:0]          tid_o,
    output logic [PC_W-1:0]           pc_o,
    output logic                      flush_o,
    output logic                      refill_busy_o
);

    typedef struct packed {
        logic [TID_W-1:0] ptr;   // rotation start
        logic [TID_W-1:0] cur;   // owner under switch-on-event
        logic [CNT_W-1:0] cnt;   // refill cycles left
    } sel_state_t;

    sel_state_t st_d, st_q;

    function automatic logic [TID_W-1:0] wrap_inc(input logic [TID_W-1:0] t);
        return (t == TID_W'(N_THREADS - 1)) ? '0 : t + 1'b1;
    endfunction

    logic                  rr_found, alt_found;
    logic [TID_W-1:0]      rr_idx, alt_idx;
    logic [N_THREADS-1:0]  alt_req;
    logic                  sel_valid, sel_flush;
    logic [TID_W-1:0]      sel_tid;
    logic [N_THREADS-1:0][PC_W-1:0] pcs;
    sel_mode_e             mode;

    assign mode    = sel_mode_e'(mode_i);
    assign alt_req = ready_i & ~(N_THREADS'(1) << st_q.cur);

    thread_rr_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_rr_pick (
        .req_i   (ready_i),
        .start_i (st_q.ptr),
        .found_o (rr_found),
        .idx_o   (rr_idx)
    );

    thread_rr_pick #(.N_THREADS(N_THREADS), .TID_W(TID_W)) u_alt_pick (
        .req_i   (alt_req),
        .start_i (wrap_inc(st_q.cur)),
        .found_o (alt_found),
        .idx_o   (alt_idx)
    );

    always_comb begin
        st_d      = st_q;
        sel_valid = 1'b0;
        sel_tid   = st_q.ptr;
        sel_flush = 1'b0;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        unique case (mode)
            SEL_COARSE: begin
                sel_tid   = st_q.cur;
                sel_valid = ready_i[st_q.cur];
                if (long_miss_i && alt_found) begin
                    sel_flush = 1'b1;
                    st_d.cur  = alt_idx;
                    st_d.ptr  = wrap_inc(alt_idx);
                    st_d.cnt  = CNT_W'(REFILL_CYCLES);
                end
            end
            SEL_PREF: begin
                if (ready_i[pref_tid_i]) begin
                    sel_valid = 1'b1;
                    sel_tid   = pref_tid_i;
                end else if (rr_found) begin
                    sel_valid = 1'b1;
                    sel_tid   = rr_idx;
                end
            end
            default: begin
                if (rr_found) begin
                    sel_valid = 1'b1;
                    sel_tid   = rr_idx;
                end
            end
        endcase
        if (mode != SEL_COARSE && sel_valid) begin
            st_d.ptr = wrap_inc(sel_tid);
            st_d.cur = sel_tid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    thread_pc_bank #(.N_THREADS(N_THREADS), .PC_W(PC_W), .TID_W(TID_W)) u_pc_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_vec_i (rst_vec_i),
        .wr_en_i   (sel_valid & ~sel_flush),
        .wr_tid_i  (sel_tid),
        .wr_pc_i   (next_pc_i),
        .pcs_o     (pcs)
    );

    assign valid_o       = sel_valid;
    assign tid_o         = sel_tid;
    assign pc_o          = pcs[sel_tid];
    assign flush_o       = sel_flush;
    assign refill_busy_o = (st_q.cnt != '0);

endmodule

// File: rtl/thread_select_chk.sv
module thread_select_chk #(
    parameter int N_THREADS     = 4,
    parameter int PC_W          = 32,
    parameter int REFILL_CYCLES = 5,
    localparam int TID_W        = (N_THREADS > 1) ? $clog2(N_THREADS) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                mode_i,
    input logic [TID_W-1:0]          pref_tid_i,
    input logic [N_THREADS-1:0]      ready_i,
    input logic                      long_miss_i,
    input logic [PC_W-1:0]           next_pc_i,
    input logic [N_THREADS*PC_W-1:0] rst_vec_i,
    input logic                      valid_o,
    input logic [TID_W-1:0]          tid_o,
    input logic [PC_W-1:0]           pc_o,
    input logic                      flush_o,
    input logic                      refill_busy_o
);

    logic seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    // R3
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ready_i[tid_o]);

    // R4
    idle_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i == '0) |-> !valid_o);

    // R8
    pref_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd2 && ready_i[pref_tid_i]) |-> (valid_o && tid_o == pref_tid_i));

    // R6 R10
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (mode_i == 2'd1 && long_miss_i));

    // R7
    refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> refill_busy_o);

    // R3
    fine_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_i == 2'd0 && $past(mode_i) == 2'd0 && $past(valid_o)
         && $countones(ready_i) >= 2) |-> (valid_o && tid_o != $past(tid_o)));

    // R5
    coarse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && mode_i == 2'd1 && $past(mode_i) == 2'd1 && !$past(flush_o))
        |-> (tid_o == $past(tid_o)));

endmodule

bind thread_select thread_select_chk #(
    .N_THREADS(N_THREADS), .PC_W(PC_W), .REFILL_CYCLES(REFILL_CYCLES)
) u_chk (.*);

// File: tb/thread_select_test.sv
`timescale 1ns/1ps
module thread_select_test;

    localparam int N  = 4;
    localparam int PW = 32;
    localparam int RF = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [1:0]    pref_tid_i = '0;
    logic [N-1:0]  ready_i = '0;
    logic          long_miss_i = 1'b0;
    logic [PW-1:0] next_pc_i = '0;
    logic [N*PW-1:0] rst_vec_i;
    logic          valid_o, flush_o, refill_busy_o;
    logic [1:0]    tid_o;
    logic [PW-1:0] pc_o;

    always #2 clk = ~clk;

    thread_select #(.N_THREADS(N), .PC_W(PW), .REFILL_CYCLES(RF)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pref_tid_i(pref_tid_i),
        .ready_i(ready_i), .long_miss_i(long_miss_i), .next_pc_i(next_pc_i),
        .rst_vec_i(rst_vec_i), .valid_o(valid_o), .tid_o(tid_o), .pc_o(pc_o),
        .flush_o(flush_o), .refill_busy_o(refill_busy_o)
    );

    int checks = 0, fails = 0;
    int m_ptr, m_cur, m_cnt, post_rst;
    logic [PW-1:0] m_pc [N];

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int pick(logic [N-1:0] req, int start);
        for (int k = 0; k < N; k++) begin
            if (req[(start + k) % N]) return (start + k) % N;
        end
        return -1;
    endfunction

    task automatic cycle(logic [1:0] md, logic [N-1:0] rdy, logic ms,
                         logic [1:0] pf, logic [PW-1:0] npc);
        int g, n_ptr, n_cur, n_cnt, alt;
        bit ev, fl;
        string tt;
        @(negedge clk);
        mode_i = md; ready_i = rdy; long_miss_i = ms; pref_tid_i = pf; next_pc_i = npc;
        #1;
        n_ptr = m_ptr; n_cur = m_cur; fl = 1'b0;
        n_cnt = (m_cnt > 0) ? m_cnt - 1 : 0;
        if (md == 2'd1) begin
            g  = m_cur;
            ev = rdy[m_cur];
            alt = pick(rdy & ~(N'(1) << m_cur), (m_cur + 1) % N);
            if (ms && alt >= 0) begin
                fl = 1'b1; n_cur = alt; n_ptr = (alt + 1) % N; n_cnt = RF;
            end
        end else begin
            if (md == 2'd2 && rdy[pf]) g = pf;
            else                      g = pick(rdy, m_ptr);
            ev = (g >= 0);
            if (ev) begin n_ptr = (g + 1) % N; n_cur = g; end
        end
        tt = (post_rst < N) ? "R2" : (md == 2'd1) ? "R5" : (md == 2'd2) ? "R8" :
             (md == 2'd3) ? "R9" : "R3";
        chk((rdy == '0) ? "R4" : tt, 64'(valid_o), 64'(ev));
        chk((md == 2'd1) ? "R6" : "R10", 64'(flush_o), 64'(fl));
        chk("R7", 64'(refill_busy_o), 64'(m_cnt != 0));
        if (ev) begin
            chk(tt, 64'(tid_o), 64'(g));
            chk((post_rst < N) ? "R2" : "R1", 64'(pc_o), 64'(m_pc[g]));
        end
        @(posedge clk);
        if (ev && !fl) m_pc[g] = npc;
        m_ptr = n_ptr; m_cur = n_cur; m_cnt = n_cnt;
        post_rst++;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        for (int i = 0; i < N; i++) begin
            rst_vec_i[i*PW +: PW] = 32'h1000_0000 + 32'(i) * 32'h0000_0400;
            m_pc[i] = 32'h1000_0000 + 32'(i) * 32'h0000_0400;
        end
        m_ptr = 0; m_cur = 0; m_cnt = 0; post_rst = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R2", 64'(flush_o), 64'd0);
        chk("R2", 64'(refill_busy_o), 64'd0);
        chk("R4", 64'(valid_o), 64'd0);
        // R2 / R3: rotation 0,1,2,3 from reset vectors
        for (int i = 0; i < 4; i++) cycle(2'd0, 4'hF, 1'b0, 2'd0, 32'h2000_0000 + 32'(i));
        // R4: idle keeps pointer
        cycle(2'd0, 4'h0, 1'b0, 2'd0, 32'hdead_0001);
        cycle(2'd0, 4'h0, 1'b0, 2'd0, 32'hdead_0002);
        cycle(2'd0, 4'hF, 1'b0, 2'd0, 32'h2100_0000);
        // R3: skip stalled
        for (int i = 0; i < 4; i++) cycle(2'd0, 4'b0101, 1'b0, 2'd0, 32'h2200_0000 + 32'(i));
        // R9
        for (int i = 0; i < 3; i++) cycle(2'd3, 4'b1011, 1'b0, 2'd0, 32'h2300_0000 + 32'(i));
        // R10: miss ignored outside policy 1
        cycle(2'd0, 4'hF, 1'b1, 2'd0, 32'h2400_0000);
        cycle(2'd2, 4'hF, 1'b1, 2'd1, 32'h2400_0001);
        // R8
        for (int i = 0; i < 3; i++) cycle(2'd2, 4'hF, 1'b0, 2'd2, 32'h2500_0000 + 32'(i));
        for (int i = 0; i < 3; i++) cycle(2'd2, 4'b1011, 1'b0, 2'd2, 32'h2600_0000 + 32'(i));
        // R5 / R6 / R7
        for (int i = 0; i < 3; i++) cycle(2'd1, 4'hF, 1'b0, 2'd0, 32'h2700_0000 + 32'(i));
        cycle(2'd1, 4'hF, 1'b1, 2'd0, 32'h2800_0000);
        for (int i = 0; i < RF + 2; i++) cycle(2'd1, 4'hF, 1'b0, 2'd0, 32'h2900_0000 + 32'(i));
        cycle(2'd1, N'(1) << m_cur, 1'b1, 2'd0, 32'h2a00_0000);
        cycle(2'd1, ~(N'(1) << m_cur), 1'b0, 2'd0, 32'h2a00_0001);
        cycle(2'd1, 4'hF, 1'b1, 2'd0, 32'h2a00_0002);
        cycle(2'd1, 4'hF, 1'b1, 2'd0, 32'h2a00_0003);
        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] md;
            logic [N-1:0] rdy;
            md = ($urandom % 8 < 3) ? 2'd1 : 2'($urandom % 4);
            for (int b = 0; b < N; b++) rdy[b] = ($urandom % 4) != 0;
            cycle(md, rdy, ($urandom % 6) == 0, 2'($urandom % 4), $urandom);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule